// File: doc/BRIEF.md
# Multi-function standby/mode pin controller

This block interprets one configurable multi-function input pin of a power-management controller. The pin can be set up as a switching-mode select for the buck rails, as a standby request, as both at once, or left unused. The raw pin is first synchronised and then deglitched. A polarity bit decides which level counts as "asserted". The filtered pin is then merged with two register-driven bits: a forced-PWM override and a register standby command.

There are two kinds of output. Each of the three buck rails gets its own forced-PWM/auto-PFM selection, and a mode change on a rail is held back while that rail is ramping. A single standby request goes to the power-state sequencer. The standby request is kept low until the device has first reached the active state outside the initialize-to-active transition. A companion pin can claim the mode function. When it does, this pin's level no longer affects the rail modes.

Top module: `mfp_stby_mode_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, `rail_pwm` becomes all ones (forced PWM) and `stby_req` becomes 0.
- R2: The pin counts as asserted when its filtered level equals `cfg_pol`: with `cfg_pol`=0 low is asserted, and with `cfg_pol`=1 high is asserted. `cfg_role` encodes 0 = mode, 1 = standby, 2 = mode and standby, 3 = unused.
- R3: A pin level sampled on fewer than `DEGLITCH_CYC` consecutive rising edges has no effect on the outputs. A level held steadily and first sampled at edge k reaches the outputs at edge k+`SYNC_STAGES`+`DEGLITCH_CYC`.
- R4: In the mode role, an asserted pin selects auto-PFM (`rail_pwm` bit 0) and a de-asserted pin selects forced PWM (bit 1). `reg_force_pwm`=1 forces PWM on every non-ramping rail in any role.
- R5: While `companion_mode` is 1, the pin has no effect on `rail_pwm`, and each non-ramping rail follows `reg_force_pwm`.
- R6: While `rail_ramping[i]` is 1, `rail_pwm[i]` holds its value. Once the flag clears, the rail takes the current target on the next edge.
- R7: `stby_req` stays 0 until the block is armed. Arming happens at an edge with `dev_active`=1 and `init_to_active`=0. Once armed, the block stays armed until reset.
- R8: In the standby role, once armed, `stby_req` = pin asserted OR `reg_stby_req`, and the rail modes follow `reg_force_pwm` only.
- R9: In the combined role, an asserted pin gives `stby_req`=1 and auto-PFM, and a de-asserted pin gives `stby_req`=0 and forced PWM. `reg_stby_req` raises the standby request without changing the rail modes.
- R10: In the combined role, pin-driven standby changes reach `stby_req` while rails are ramping, even though the rail modes are held.
- R11: In the unused role, the pin has no effect: `stby_req` follows `reg_stby_req` (once armed) and the rails follow `reg_force_pwm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_raw | input | 1 | Asynchronous multi-function pin |
| cfg_role | input | 2 | Pin role: 0 mode, 1 standby, 2 both, 3 unused |
| cfg_pol | input | 1 | Pin polarity; the asserted level equals this bit |
| reg_force_pwm | input | 1 | Register override forcing PWM on all rails |
| reg_stby_req | input | 1 | Register standby command |
| companion_mode | input | 1 | Companion pin owns the mode function |
| dev_active | input | 1 | Power-state machine is in the active state |
| init_to_active | input | 1 | Initialize-to-active transition in progress |
| rail_ramping | input | 3 | Per-rail ramp-in-progress flags |
| rail_pwm | output | 3 | Per-rail mode: 1 forced PWM, 0 auto-PFM |
| stby_req | output | 1 | Standby request to the sequencer |

## Verification
The embedded properties check these rules on every cycle:
- A ramping rail keeps its mode.
- The force override and the companion claim decide the rail mode on the following edge.
- The unused role never raises standby on its own.
- No standby request appears before arming.
- The filtered pin moves only when the deglitch count completes.

Some behaviour depends on multi-cycle stimulus histories, so only the bench scenarios, compared cycle by cycle against a behavioural model, can show it:
- The exact end-to-end latency.
- Rejection of short pulses.
- The polarity mapping.
- The combined-role pairing of standby with auto-PFM.

// File: rtl/mfp_pkg.sv
// Shared definitions for the multi-function pin controller.
// Assumes the role encoding is fixed by software configuration.
package mfp_pkg;
    typedef enum logic [1:0] {
        PIN_ROLE_MODE = 2'd0,
        PIN_ROLE_STBY = 2'd1,
        PIN_ROLE_BOTH = 2'd2,
        PIN_ROLE_OFF  = 2'd3
    } pin_role_e;

    // True when the role lets the pin drive rail modes.
    function automatic logic role_drives_mode(pin_role_e r);
        return (r == PIN_ROLE_MODE) || (r == PIN_ROLE_BOTH);
    endfunction

    // True when the role lets the pin request standby.
    function automatic logic role_drives_stby(pin_role_e r);
        return (r == PIN_ROLE_STBY) || (r == PIN_ROLE_BOTH);
    endfunction
endpackage

// File: rtl/mfp_pin_filter.sv
// Synchroniser plus deglitch counter for the raw pin.
// Assumes rest_level is static after reset; both the chain and the
// filtered level reset to it, so no edge is seen on reset release.
module mfp_pin_filter #(
    parameter int SYNC_STAGES  = 2,
    parameter int DEGLITCH_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    input  logic rest_level,
    output logic filt_level
);
    localparam int CNT_W = $clog2(DEGLITCH_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEGLITCH_CYC - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sync_out;
    logic [CNT_W-1:0]       cnt_q;
    logic                   filt_q;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            // Shift the pin through a multi-stage synchroniser.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= {SYNC_STAGES{rest_level}};
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};
            end
        end else begin : g_single
            // Single-stage capture when only one stage is configured.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= rest_level;
                else        sync_q <= pin_raw;
            end
        end
    endgenerate

    assign sync_out = sync_q[SYNC_STAGES-1];

    // Count consecutive disagreeing samples; adopt the new level at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            filt_q <= rest_level;
        end else if (sync_out != filt_q) begin
            if (cnt_q == CNT_LAST) begin
                cnt_q  <= '0;
                filt_q <= sync_out;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign filt_level = filt_q;

    // R3: the filtered level only moves when the count reached its limit.
    p_filter_waits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_q) |-> ($past(cnt_q) == CNT_LAST));
endmodule

// File: rtl/mfp_role_decode.sv
// Combinational interpretation of the filtered pin by role and polarity.
// Produces the common mode target for all rails and the pin standby wish.
module mfp_role_decode
    import mfp_pkg::*;
(
    input  logic      filt_level,
    input  pin_role_e role,
    input  logic      pol,
    input  logic      companion_mode,
    input  logic      reg_force_pwm,
    output logic      pin_asserted,
    output logic      tgt_pwm,
    output logic      pin_stby
);
    logic mode_owned;

    // Derive assertion, mode target and standby wish from the pin.
    always_comb begin
        pin_asserted = (filt_level == pol);
        mode_owned   = role_drives_mode(role) && !companion_mode;
        tgt_pwm      = reg_force_pwm || (mode_owned && !pin_asserted);
        pin_stby     = role_drives_stby(role) && pin_asserted;
    end
endmodule

// File: rtl/mfp_rail_mode.sv
// Per-rail mode register that holds while its rail is ramping.
// Assumes the ramp flag is synchronous to clk.
module mfp_rail_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic tgt_pwm,
    input  logic ramping,
    output logic pwm
);
    // Take the new target only when the rail is not ramping.
    always_ff @(posedge clk) begin
        if (!rst_n)        pwm <= 1'b1;
        else if (!ramping) pwm <= tgt_pwm;
    end

    // R6: mode is frozen during a ramp.
    p_ramp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ramping |=> $stable(pwm));
endmodule

// File: rtl/mfp_stby_gate.sv
// Arms standby once the device has been active and registers the request.
// Assumes init_to_active is high only during the first power-up ramp.
module mfp_stby_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic dev_active,
    input  logic init_to_active,
    input  logic stby_wish,
    output logic stby_req
);
    logic armed_q;

    // Sticky arming flag, set by an active state outside initialisation.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_q || (dev_active && !init_to_active);
    end

    // Register the gated standby request.
    always_ff @(posedge clk) begin
        if (!rst_n) stby_req <= 1'b0;
        else        stby_req <= armed_q && stby_wish;
    end

    // R7: no standby request while not yet armed.
    p_unarmed_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> !stby_req);
endmodule

// File: rtl/mfp_stby_mode_ctrl.sv
// Top of the multi-function pin controller: filter, decode, per-rail
// blanking and standby gating. Assumes cfg_role and cfg_pol only change
// while rst_n is low.
module mfp_stby_mode_ctrl
    import mfp_pkg::*;
#(
    parameter int N_RAILS      = 3,
    parameter int SYNC_STAGES  = 2,
    parameter int DEGLITCH_CYC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin_raw,
    input  logic [1:0]         cfg_role,
    input  logic               cfg_pol,
    input  logic               reg_force_pwm,
    input  logic               reg_stby_req,
    input  logic               companion_mode,
    input  logic               dev_active,
    input  logic               init_to_active,
    input  logic [N_RAILS-1:0] rail_ramping,
    output logic [N_RAILS-1:0] rail_pwm,
    output logic               stby_req
);
    pin_role_e role;
    logic      filt_level;
    logic      pin_asserted;
    logic      tgt_pwm;
    logic      pin_stby;
    logic      stby_wish;

    assign role = pin_role_e'(cfg_role);

    mfp_pin_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .DEGLITCH_CYC(DEGLITCH_CYC)
    ) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_raw   (pin_raw),
        .rest_level(~cfg_pol),
        .filt_level(filt_level)
    );

    mfp_role_decode u_decode (
        .filt_level    (filt_level),
        .role          (role),
        .pol           (cfg_pol),
        .companion_mode(companion_mode),
        .reg_force_pwm (reg_force_pwm),
        .pin_asserted  (pin_asserted),
        .tgt_pwm       (tgt_pwm),
        .pin_stby      (pin_stby)
    );

    generate
        for (genvar i = 0; i < N_RAILS; i++) begin : g_rail
            mfp_rail_mode u_rail (
                .clk    (clk),
                .rst_n  (rst_n),
                .tgt_pwm(tgt_pwm),
                .ramping(rail_ramping[i]),
                .pwm    (rail_pwm[i])
            );

            // R4: the override reaches every idle rail on the next edge.
            p_force_pwm_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_force_pwm && !rail_ramping[i]) |=> rail_pwm[i]);

            // R5: a claimed mode function leaves the rail on the register bit.
            p_companion_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (companion_mode && !reg_force_pwm && !rail_ramping[i]) |=> !rail_pwm[i]);
        end
    endgenerate

    // Merge pin-derived and register standby wishes.
    always_comb stby_wish = pin_stby || reg_stby_req;

    mfp_stby_gate u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .dev_active    (dev_active),
        .init_to_active(init_to_active),
        .stby_wish     (stby_wish),
        .stby_req      (stby_req)
    );

    // R11: an unused pin never raises standby on its own.
    p_role_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_role == 2'd3 && !reg_stby_req) |=> !stby_req);

    // R2: pin assertion is a pure function of level and polarity.
    always_comb begin
        if (rst_n) begin
            p_polarity_r2: assert (pin_asserted == (filt_level == cfg_pol));
        end
    end
endmodule

// File: tb/mfp_stby_mode_ctrl_test.sv
module mfp_stby_mode_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 3;
    localparam int SYN = 2;
    localparam int DG = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_raw = 1'b1;
    logic [1:0] cfg_role = 2'd1;
    logic cfg_pol = 1'b0;
    logic reg_force_pwm = 1'b0;
    logic reg_stby_req = 1'b0;
    logic companion_mode = 1'b0;
    logic dev_active = 1'b0;
    logic init_to_active = 1'b1;
    logic [NR-1:0] rail_ramping = '0;
    logic [NR-1:0] rail_pwm;
    logic stby_req;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    mfp_stby_mode_ctrl #(.N_RAILS(NR), .SYNC_STAGES(SYN), .DEGLITCH_CYC(DG)) uut (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .cfg_role(cfg_role),
        .cfg_pol(cfg_pol), .reg_force_pwm(reg_force_pwm), .reg_stby_req(reg_stby_req),
        .companion_mode(companion_mode), .dev_active(dev_active),
        .init_to_active(init_to_active), .rail_ramping(rail_ramping),
        .rail_pwm(rail_pwm), .stby_req(stby_req));

    // Behavioural reference model
    logic q[$];
    logic m_filt;
    int   m_run;
    logic m_armed;
    logic [NR-1:0] m_pwm;
    logic m_stby;
    bit   started = 0;

    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            q = {};
            for (int i = 0; i < SYN; i++) q.push_back(~cfg_pol);
            m_filt = ~cfg_pol; m_run = 0; m_armed = 0; m_pwm = '1; m_stby = 0;
        end else begin
            logic asrt, own_mode, own_stby, tgt, seen;
            asrt = (m_filt == cfg_pol);
            own_mode = (cfg_role == 0 || cfg_role == 2) && !companion_mode;
            own_stby = (cfg_role == 1 || cfg_role == 2);
            tgt = reg_force_pwm | (own_mode & ~asrt);
            for (int i = 0; i < NR; i++) if (!rail_ramping[i]) m_pwm[i] = tgt;
            m_stby = m_armed & ((own_stby & asrt) | reg_stby_req);
            m_armed = m_armed | (dev_active & ~init_to_active);
            seen = q.pop_front();
            q.push_back(pin_raw);
            if (seen != m_filt) begin
                m_run++;
                if (m_run >= DG) begin m_filt = seen; m_run = 0; end
            end else m_run = 0;
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (rail_pwm !== m_pwm || stby_req !== m_stby) begin
                failures++;
                $display("FAIL %s model: actual pwm=%b stby=%b expected pwm=%b stby=%b",
                         cur_req, rail_pwm, stby_req, m_pwm, m_stby);
            end
        end
    end

    task automatic expect_out(string req, logic [NR-1:0] ep, logic es);
        checks++;
        if (rail_pwm !== ep || stby_req !== es) begin
            failures++;
            $display("FAIL %s: actual pwm=%b stby=%b expected pwm=%b stby=%b",
                     req, rail_pwm, stby_req, ep, es);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(logic [1:0] role, logic pol, logic pin);
        rst_n = 0; cfg_role = role; cfg_pol = pol; pin_raw = pin;
        reg_force_pwm = 0; reg_stby_req = 0; companion_mode = 0; rail_ramping = '0;
        step(3);
        expect_out("R1", 3'b111, 1'b0);
        rst_n = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // Standby role, low asserted
        cur_req = "R7";
        dev_active = 0; init_to_active = 1;
        do_reset(2'd1, 1'b0, 1'b1);
        pin_raw = 0; step(10);
        expect_out("R7", 3'b000, 1'b0);
        dev_active = 1; step(10);
        expect_out("R7", 3'b000, 1'b0);
        cur_req = "R8";
        init_to_active = 0; step(10);
        expect_out("R8", 3'b000, 1'b1);
        dev_active = 0; pin_raw = 1; step(10);
        expect_out("R8", 3'b000, 1'b0);
        pin_raw = 0; step(10);
        expect_out("R7", 3'b000, 1'b1);
        pin_raw = 1; reg_stby_req = 1; step(10);
        expect_out("R8", 3'b000, 1'b1);

        // Mode role, low asserted
        cur_req = "R4";
        dev_active = 1;
        do_reset(2'd0, 1'b0, 1'b1);
        step(10);
        expect_out("R4", 3'b111, 1'b0);
        pin_raw = 0; step(10);
        expect_out("R2", 3'b000, 1'b0);
        cur_req = "R3";
        pin_raw = 1; step(3); pin_raw = 0; step(10);
        expect_out("R3", 3'b000, 1'b0);
        pin_raw = 1; step(6);
        expect_out("R3", 3'b000, 1'b0);
        step(1);
        expect_out("R3", 3'b111, 1'b0);
        pin_raw = 0; step(10);
        cur_req = "R4";
        reg_force_pwm = 1; step(3);
        expect_out("R4", 3'b111, 1'b0);
        reg_force_pwm = 0; step(3);
        expect_out("R4", 3'b000, 1'b0);
        cur_req = "R5";
        companion_mode = 1; pin_raw = 1; step(10);
        expect_out("R5", 3'b000, 1'b0);
        reg_force_pwm = 1; step(3);
        expect_out("R5", 3'b111, 1'b0);
        reg_force_pwm = 0; companion_mode = 0; step(10);
        expect_out("R5", 3'b111, 1'b0);
        cur_req = "R6";
        rail_ramping = 3'b010; pin_raw = 0; step(10);
        expect_out("R6", 3'b010, 1'b0);
        rail_ramping = 3'b000; step(2);
        expect_out("R6", 3'b000, 1'b0);

        // Mode role, high asserted
        cur_req = "R2";
        do_reset(2'd0, 1'b1, 1'b0);
        step(10);
        expect_out("R2", 3'b111, 1'b0);
        pin_raw = 1; step(10);
        expect_out("R2", 3'b000, 1'b0);

        // Combined role, high asserted
        cur_req = "R9";
        do_reset(2'd2, 1'b1, 1'b0);
        step(10);
        expect_out("R9", 3'b111, 1'b0);
        pin_raw = 1; step(10);
        expect_out("R9", 3'b000, 1'b1);
        pin_raw = 0; reg_stby_req = 1; step(10);
        expect_out("R9", 3'b111, 1'b1);
        reg_stby_req = 0; step(3);
        expect_out("R9", 3'b111, 1'b0);
        cur_req = "R10";
        rail_ramping = 3'b111; pin_raw = 1; step(10);
        expect_out("R10", 3'b111, 1'b1);
        rail_ramping = 3'b000; step(3);
        expect_out("R10", 3'b000, 1'b1);

        // Unused role
        cur_req = "R11";
        do_reset(2'd3, 1'b0, 1'b1);
        step(10);
        expect_out("R11", 3'b000, 1'b0);
        pin_raw = 0; step(10);
        expect_out("R11", 3'b000, 1'b0);
        reg_force_pwm = 1; step(3);
        expect_out("R11", 3'b111, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule